// File: doc/BRIEF.md
# Two-Thread Instruction Address Translation Buffer

This block is the first-level instruction translation buffer of a core that runs two hardware threads. It maps a 48-bit virtual fetch address to a 40-bit physical address. Small 4 KB pages live in a 128-entry, 4-way set-associative array that both threads share, with the thread id kept in each tag. Large pages of 2 MB or 4 MB live in seven fully-associative entries that belong to each thread alone. A lookup searches the small-page set and the requesting thread's large-page entries in the same cycle. It reports a hit or a miss, with the physical address, one cycle after the request is accepted.

Lookups form a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever no response is waiting or the waiting response is being taken in that cycle. A response stays on the output, unchanged, until `rsp_ready` takes it. The fill and invalidate pins are plain control with no handshake, and a fill is never refused. A fill installs one translation, either small or large. Invalidate-all empties the whole buffer. A per-thread invalidate empties that thread's large-page entries and its small-page entries.

Top module: `itlb_two_thread`

## Requirements
- R1: A small-page hit returns the physical address {stored frame bits 39:12, request VA bits 11:0}. The set is chosen by VA bits 16:12. `rsp_valid` rises on the clock edge that follows the edge where the request is accepted.
- R2: A small-page entry hits only for the thread id it was filled with. The same VA may hold separate translations for thread 0 and thread 1.
- R3: Large entries are private to their thread. A 2 MB entry (`fill_size4m`=0) matches on VA bits 47:21 and passes VA bits 20:0 through to the physical address.
- R4: A 4 MB entry (`fill_size4m`=1) matches on VA bits 47:22 and ignores VA bit 21. It passes VA bits 21:0 through to the physical address.
- R5: When both a large and a small entry hit, the large-page translation is returned. A miss returns `rsp_hit`=0 with `rsp_pa`=0.
- R6: A small fill chooses its way as follows:
  - If a valid entry already holds the same VA tag and thread, that entry is overwritten.
  - Otherwise the lowest invalid way of the set is used.
  - Otherwise the victim comes from the set's 3-bit tree pseudo-LRU. The root bit selects the half (0 means ways 0-1, 1 means ways 2-3). Each half has one bit that selects the lower or the upper way.
  - Fills and accepted lookup hits point the tree away from the way they touch.
- R7: A large fill writes the thread's round-robin slot and then advances it. The pointer counts 0 to 6 and wraps back to 0, so the eighth fill after a reset or invalidate replaces the first.
- R8: Invalidate-all clears every entry and returns every pseudo-LRU tree and round-robin pointer to zero.
- R9: A per-thread invalidate clears that thread's large and small entries and resets its pointer. The other thread's entries stay valid.
- R10: A fill in a cycle with any invalidate is dropped. A lookup accepted in an invalidate cycle sees the contents from before the invalidate.
- R11: While `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is 0 and `rsp_hit`/`rsp_pa` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be taken |
| req_tid | input | 1 | Requesting thread |
| req_va | input | 48 | Virtual fetch address |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_hit | output | 1 | Translation found |
| rsp_pa | output | 40 | Physical address (0 on a miss) |
| fill_valid | input | 1 | Install a translation this cycle |
| fill_tid | input | 1 | Owning thread of the fill |
| fill_large | input | 1 | 1: large-page entry, 0: small-page entry |
| fill_size4m | input | 1 | Large page size, 1 = 4 MB, 0 = 2 MB |
| fill_va | input | 48 | Virtual page address of the fill |
| fill_pa | input | 40 | Physical page address of the fill |
| inv_all | input | 1 | Clear every entry |
| inv_thread | input | 1 | Clear the entries of one thread |
| inv_tid | input | 1 | Thread cleared by `inv_thread` |

## Verification
The bench builds the block with its default parameters: 48/40-bit addresses, 32 sets of 4 ways and 7 large entries per thread. These are small enough that four fills fill a set, so the next fill has to evict by pseudo-LRU, and eight fills wrap a thread's round-robin pointer. Addresses are chosen so that bit 21 separates two 2 MB pages but falls inside a single 4 MB page. The bench also places the same VA in both threads and in both structures, which brings the thread-tag, size-mask and priority paths into reach.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  localparam int PG_SHIFT  = 12;  // small page offset bits
  localparam int LP2_SHIFT = 21;  // 2 MB offset bits
  localparam int LP4_SHIFT = 22;  // 4 MB offset bits
  localparam int SP_WAYS   = 4;   // tree pseudo-LRU is built for four ways
  localparam int N_THREADS = 2;

  typedef enum logic {LPG_2M = 1'b0, LPG_4M = 1'b1} lpg_size_e;

  // tree bits: [0] root (0 -> ways 0/1), [1] lower pair, [2] upper pair
  function automatic logic [1:0] plru_victim(input logic [2:0] t);
    if (!t[0]) return t[1] ? 2'd1 : 2'd0;
    else       return t[2] ? 2'd3 : 2'd2;
  endfunction

  function automatic logic [2:0] plru_touch(input logic [2:0] t, input logic [1:0] w);
    logic [2:0] n;
    n = t;
    if (!w[1]) begin
      n[0] = 1'b1;
      n[1] = ~w[0];
    end else begin
      n[0] = 1'b0;
      n[2] = ~w[0];
    end
    return n;
  endfunction
endpackage

// File: rtl/itlb_small_array.sv
module itlb_small_array
  import itlb_pkg::*;
#(
  parameter int VA_W     = 48,
  parameter int PA_W     = 40,
  parameter int SET_BITS = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [VA_W-1:0] lk_va,
  input  logic            lk_tid,
  output logic            lk_hit,
  output logic [PA_W-1:0] lk_pa,
  input  logic            touch_en,
  input  logic            fill_en,
  input  logic [VA_W-1:0] fill_va,
  input  logic            fill_tid,
  input  logic [PA_W-1:0] fill_pa,
  input  logic            inv_all,
  input  logic            inv_thr,
  input  logic            inv_tid
);
  localparam int SETS  = 1 << SET_BITS;
  localparam int TAG_W = VA_W - PG_SHIFT - SET_BITS;
  localparam int PPN_W = PA_W - PG_SHIFT;
  localparam int WAYS  = SP_WAYS;

  logic [WAYS-1:0]  vld_q [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic             tid_q [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q [SETS][WAYS];
  logic [2:0]       tree_q [SETS];

  logic [SET_BITS-1:0] lk_set, fl_set;
  logic [TAG_W-1:0]    lk_tag, fl_tag;
  logic [WAYS-1:0]     hit_vec, fl_match;
  logic [1:0]          lk_way, fl_way;

  assign lk_set = lk_va[PG_SHIFT +: SET_BITS];
  assign lk_tag = lk_va[VA_W-1 -: TAG_W];
  assign fl_set = fill_va[PG_SHIFT +: SET_BITS];
  assign fl_tag = fill_va[VA_W-1 -: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way_cmp
    assign hit_vec[w]  = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag)
                         && (tid_q[lk_set][w] == lk_tid);
    assign fl_match[w] = vld_q[fl_set][w] && (tag_q[fl_set][w] == fl_tag)
                         && (tid_q[fl_set][w] == fill_tid);
  end

  always_comb begin
    lk_hit = |hit_vec;
    lk_way = '0;
    lk_pa  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) begin
        lk_way = 2'(w);
        lk_pa  = {ppn_q[lk_set][w], lk_va[PG_SHIFT-1:0]};
      end
    end
  end

  always_comb begin
    fl_way = plru_victim(tree_q[fl_set]);
    if (|fl_match) begin
      for (int w = WAYS - 1; w >= 0; w--)
        if (fl_match[w]) fl_way = 2'(w);
    end else if (!(&vld_q[fl_set])) begin
      for (int w = WAYS - 1; w >= 0; w--)
        if (!vld_q[fl_set][w]) fl_way = 2'(w);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || inv_all) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        tree_q[s] <= '0;
      end
    end else if (inv_thr) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          if (tid_q[s][w] == inv_tid) vld_q[s][w] <= 1'b0;
    end else begin
      if (touch_en) tree_q[lk_set] <= plru_touch(tree_q[lk_set], lk_way);
      if (fill_en) begin
        vld_q[fl_set][fl_way] <= 1'b1;
        tree_q[fl_set]        <= plru_touch(tree_q[fl_set], fl_way);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !inv_all && !inv_thr) begin
      tag_q[fl_set][fl_way] <= fl_tag;
      tid_q[fl_set][fl_way] <= fill_tid;
      ppn_q[fl_set][fl_way] <= fill_pa[PA_W-1:PG_SHIFT];
    end
  end
endmodule

// File: rtl/itlb_large_bank.sv
module itlb_large_bank
  import itlb_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int PA_W    = 40,
  parameter int ENTRIES = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [VA_W-1:0] lk_va,
  output logic            lk_hit,
  output logic [PA_W-1:0] lk_pa,
  input  logic            fill_en,
  input  lpg_size_e       fill_size,
  input  logic [VA_W-1:0] fill_va,
  input  logic [PA_W-1:0] fill_pa,
  input  logic            clr
);
  localparam int VT_W  = VA_W - LP2_SHIFT;
  localparam int PP_W  = PA_W - LP2_SHIFT;
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld_q;
  lpg_size_e          sz_q   [ENTRIES];
  logic [VT_W-1:0]    vtag_q [ENTRIES];
  logic [PP_W-1:0]    ppn_q  [ENTRIES];
  logic [PTR_W-1:0]   ptr_q;

  logic [ENTRIES-1:0] hit_vec;
  logic [PA_W-1:0]    ent_pa [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_comb begin
      if (sz_q[e] == LPG_4M) begin
        hit_vec[e] = vld_q[e] && (vtag_q[e][VT_W-1:1] == lk_va[VA_W-1:LP4_SHIFT]);
        ent_pa[e]  = {ppn_q[e][PP_W-1:1], lk_va[LP4_SHIFT-1:0]};
      end else begin
        hit_vec[e] = vld_q[e] && (vtag_q[e] == lk_va[VA_W-1:LP2_SHIFT]);
        ent_pa[e]  = {ppn_q[e], lk_va[LP2_SHIFT-1:0]};
      end
    end
  end

  always_comb begin
    lk_hit = |hit_vec;
    lk_pa  = '0;
    for (int e = ENTRIES - 1; e >= 0; e--)
      if (hit_vec[e]) lk_pa = ent_pa[e];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (fill_en) begin
      vld_q[ptr_q] <= 1'b1;
      ptr_q        <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !clr) begin
      sz_q[ptr_q]   <= fill_size;
      vtag_q[ptr_q] <= fill_va[VA_W-1:LP2_SHIFT];
      ppn_q[ptr_q]  <= fill_pa[PA_W-1:LP2_SHIFT];
    end
  end
endmodule

// File: rtl/itlb_two_thread.sv
module itlb_two_thread
  import itlb_pkg::*;
#(
  parameter int VA_W       = 48,
  parameter int PA_W       = 40,
  parameter int SET_BITS   = 5,
  parameter int LP_ENTRIES = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_tid,
  input  logic [VA_W-1:0] req_va,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic            rsp_hit,
  output logic [PA_W-1:0] rsp_pa,
  input  logic            fill_valid,
  input  logic            fill_tid,
  input  logic            fill_large,
  input  logic            fill_size4m,
  input  logic [VA_W-1:0] fill_va,
  input  logic [PA_W-1:0] fill_pa,
  input  logic            inv_all,
  input  logic            inv_thread,
  input  logic            inv_tid
);
  logic inv_any, req_fire, sp_fill;
  logic sp_hit;
  logic [PA_W-1:0] sp_pa;
  logic [N_THREADS-1:0] lp_hit_t;
  logic [PA_W-1:0]      lp_pa_t [N_THREADS];
  logic lp_hit;
  logic [PA_W-1:0] lp_pa, pa_next;

  assign inv_any   = inv_all | inv_thread;
  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;
  assign sp_fill   = fill_valid && !fill_large && !inv_any;

  itlb_small_array #(
    .VA_W(VA_W), .PA_W(PA_W), .SET_BITS(SET_BITS)
  ) u_small (
    .clk(clk), .rst_n(rst_n),
    .lk_va(req_va), .lk_tid(req_tid), .lk_hit(sp_hit), .lk_pa(sp_pa),
    .touch_en(req_fire && sp_hit),
    .fill_en(sp_fill), .fill_va(fill_va), .fill_tid(fill_tid), .fill_pa(fill_pa),
    .inv_all(inv_all), .inv_thr(inv_thread), .inv_tid(inv_tid)
  );

  for (genvar t = 0; t < N_THREADS; t++) begin : g_thread
    logic bank_fill, bank_clr;
    assign bank_fill = fill_valid && fill_large && !inv_any && (fill_tid == 1'(t));
    assign bank_clr  = inv_all || (inv_thread && (inv_tid == 1'(t)));

    itlb_large_bank #(
      .VA_W(VA_W), .PA_W(PA_W), .ENTRIES(LP_ENTRIES)
    ) u_large (
      .clk(clk), .rst_n(rst_n),
      .lk_va(req_va), .lk_hit(lp_hit_t[t]), .lk_pa(lp_pa_t[t]),
      .fill_en(bank_fill), .fill_size(lpg_size_e'(fill_size4m)),
      .fill_va(fill_va), .fill_pa(fill_pa), .clr(bank_clr)
    );
  end

  assign lp_hit = lp_hit_t[req_tid];
  assign lp_pa  = lp_pa_t[req_tid];

  always_comb begin
    if (lp_hit)      pa_next = lp_pa;
    else if (sp_hit) pa_next = sp_pa;
    else             pa_next = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pa    <= '0;
    end else if (req_fire) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= lp_hit || sp_hit;
      rsp_pa    <= pa_next;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/itlb_checker.sv
module itlb_checker #(
  parameter int VA_W = 48,
  parameter int PA_W = 40
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_va,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic            rsp_hit,
  input logic [PA_W-1:0] rsp_pa,
  input logic            inv_all
);
  logic [11:0] cap_off;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cap_off <= '0;
    else if (req_valid && req_ready) cap_off <= req_va[11:0];
  end

  // R11: a waiting response blocks new requests and holds its contents
  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_pa)));

  // R5: miss carries a zero address
  p_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_pa == '0));

  // R1: page offset passes through on every hit
  p_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (rsp_pa[11:0] == cap_off));

  // R1: a response appears only after an accepted request
  p_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready));

  // R8: the first lookup after invalidate-all misses
  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all ##1 (req_valid && req_ready)) |=> !rsp_hit);
endmodule

bind itlb_two_thread itlb_checker #(.VA_W(VA_W), .PA_W(PA_W)) u_itlb_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_va(req_va), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_hit(rsp_hit), .rsp_pa(rsp_pa), .inv_all(inv_all)
);

// File: tb/tb_itlb_two_thread.sv
`timescale 1ns/1ps
module tb_itlb_two_thread;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_tid, rsp_ready;
  logic [47:0] req_va;
  logic        req_ready, rsp_valid, rsp_hit;
  logic [39:0] rsp_pa;
  logic        fill_valid, fill_tid, fill_large, fill_size4m;
  logic [47:0] fill_va;
  logic [39:0] fill_pa;
  logic        inv_all, inv_thread, inv_tid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  itlb_two_thread dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_tid(req_tid), .req_va(req_va),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_pa(rsp_pa),
    .fill_valid(fill_valid), .fill_tid(fill_tid), .fill_large(fill_large),
    .fill_size4m(fill_size4m), .fill_va(fill_va), .fill_pa(fill_pa),
    .inv_all(inv_all), .inv_thread(inv_thread), .inv_tid(inv_tid)
  );

  localparam logic [1:0] OP_FILL = 2'd0, OP_LOOK = 2'd1, OP_INVT = 2'd2, OP_INVA = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic        tid;
    logic        lg;
    logic        s4;
    logic [47:0] va;
    logic [39:0] pa;   // fill address, or expected address for a lookup
    logic        hit;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{OP_FILL, 1'b0, 1'b0, 1'b0, 48'h000012345000, 40'h00ABCDE000, 1'b0, 8'd1},
    '{OP_LOOK, 1'b0, 1'b0, 1'b0, 48'h000012345ABC, 40'h00ABCDEABC, 1'b1, 8'd1},  // R1
    '{OP_LOOK, 1'b1, 1'b0, 1'b0, 48'h000012345ABC, 40'h0000000000, 1'b0, 8'd2},  // R2
    '{OP_FILL, 1'b1, 1'b0, 1'b0, 48'h000012345000, 40'h0055555000, 1'b0, 8'd2},
    '{OP_LOOK, 1'b1, 1'b0, 1'b0, 48'h000012345ABC, 40'h0055555ABC, 1'b1, 8'd2},  // R2
    '{OP_LOOK, 1'b0, 1'b0, 1'b0, 48'h000012345ABC, 40'h00ABCDEABC, 1'b1, 8'd2},  // R2
    '{OP_FILL, 1'b1, 1'b1, 1'b0, 48'h000040200000, 40'h0080600000, 1'b0, 8'd3},
    '{OP_LOOK, 1'b1, 1'b0, 1'b0, 48'h000040212345, 40'h0080612345, 1'b1, 8'd3},  // R3
    '{OP_LOOK, 1'b1, 1'b0, 1'b0, 48'h000040400000, 40'h0000000000, 1'b0, 8'd3},  // R3 bit 21
    '{OP_LOOK, 1'b0, 1'b0, 1'b0, 48'h000040212345, 40'h0000000000, 1'b0, 8'd3},  // R3 private
    '{OP_FILL, 1'b0, 1'b1, 1'b1, 48'h000080000000, 40'h0000400000, 1'b0, 8'd4},
    '{OP_LOOK, 1'b0, 1'b0, 1'b0, 48'h0000803FFFFF, 40'h00007FFFFF, 1'b1, 8'd4},  // R4
    '{OP_LOOK, 1'b0, 1'b0, 1'b0, 48'h000080200000, 40'h0000600000, 1'b1, 8'd4},  // R4 bit 21 ignored
    '{OP_LOOK, 1'b0, 1'b0, 1'b0, 48'h000080400000, 40'h0000000000, 1'b0, 8'd4},  // R4
    '{OP_INVT, 1'b1, 1'b0, 1'b0, 48'h0,            40'h0,          1'b0, 8'd9},
    '{OP_LOOK, 1'b1, 1'b0, 1'b0, 48'h000040212345, 40'h0000000000, 1'b0, 8'd9},  // R9
    '{OP_LOOK, 1'b1, 1'b0, 1'b0, 48'h000012345ABC, 40'h0000000000, 1'b0, 8'd9},  // R9
    '{OP_LOOK, 1'b0, 1'b0, 1'b0, 48'h000012345ABC, 40'h00ABCDEABC, 1'b1, 8'd9},  // R9
    '{OP_LOOK, 1'b0, 1'b0, 1'b0, 48'h0000803FFFFF, 40'h00007FFFFF, 1'b1, 8'd9},  // R9
    '{OP_INVA, 1'b0, 1'b0, 1'b0, 48'h0,            40'h0,          1'b0, 8'd8},
    '{OP_LOOK, 1'b0, 1'b0, 1'b0, 48'h000012345ABC, 40'h0000000000, 1'b0, 8'd8},  // R8
    '{OP_LOOK, 1'b0, 1'b0, 1'b0, 48'h0000803FFFFF, 40'h0000000000, 1'b0, 8'd8}   // R8
  };

  task automatic check(input bit ok, input string rq, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic do_fill(input logic tid, input logic lg, input logic s4,
                         input logic [47:0] va, input logic [39:0] pa);
    @(negedge clk);
    fill_valid = 1'b1; fill_tid = tid; fill_large = lg; fill_size4m = s4;
    fill_va = va; fill_pa = pa;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_inv(input logic all, input logic tid);
    @(negedge clk);
    inv_all = all; inv_thread = !all; inv_tid = tid;
    @(negedge clk);
    inv_all = 1'b0; inv_thread = 1'b0;
  endtask

  task automatic do_look(input logic tid, input logic [47:0] va, input logic eh,
                         input logic [39:0] ep, input string rq);
    @(negedge clk);
    req_valid = 1'b1; req_tid = tid; req_va = va;
    @(posedge clk);
    #1;
    check(rsp_valid && (rsp_hit == eh) && (rsp_pa == ep), rq,
          {6'd0, rsp_valid, rsp_hit, rsp_pa}, {6'd0, 1'b1, eh, ep});
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [47:0] set3_va(input int k);
    return 48'(k) * 48'h20000 + 48'h3000;
  endfunction
  function automatic logic [39:0] set3_pa(input int k);
    return {28'(k + 256), 12'h000};
  endfunction

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_tid = 1'b0; req_va = '0; rsp_ready = 1'b1;
    fill_valid = 1'b0; fill_tid = 1'b0; fill_large = 1'b0; fill_size4m = 1'b0;
    fill_va = '0; fill_pa = '0; inv_all = 1'b0; inv_thread = 1'b0; inv_tid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(!rsp_valid && req_ready && !rsp_hit && rsp_pa == '0, "reset",
          {6'd0, rsp_valid, req_ready, rsp_pa}, {6'd0, 2'b01, 40'h0});
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_FILL: do_fill(VEC[i].tid, VEC[i].lg, VEC[i].s4, VEC[i].va, VEC[i].pa);
        OP_LOOK: do_look(VEC[i].tid, VEC[i].va, VEC[i].hit, VEC[i].pa,
                         $sformatf("R%0d vec %0d", VEC[i].rq, i));
        OP_INVT: do_inv(1'b0, VEC[i].tid);
        default: do_inv(1'b1, 1'b0);
      endcase
    end

    // R6: four fills take the invalid ways 0..3; a hit on way 0 then steers the fifth onto way 2
    for (int k = 1; k <= 4; k++) do_fill(1'b0, 1'b0, 1'b0, set3_va(k), set3_pa(k));
    do_look(1'b0, set3_va(1) | 48'h10, 1'b1, set3_pa(1) | 40'h10, "R6 touch");
    do_fill(1'b0, 1'b0, 1'b0, set3_va(5), set3_pa(5));
    do_look(1'b0, set3_va(3) | 48'h10, 1'b0, 40'h0, "R6 victim");
    for (int k = 1; k <= 5; k++)
      if (k != 3) do_look(1'b0, set3_va(k) | 48'h10, 1'b1, set3_pa(k) | 40'h10, "R6 kept");

    // R6: refilling an existing translation replaces it
    do_fill(1'b0, 1'b0, 1'b0, 48'h000000007000, 40'h0000001000);
    do_fill(1'b0, 1'b0, 1'b0, 48'h000000007000, 40'h0000002000);
    do_look(1'b0, 48'h000000007004, 1'b1, 40'h0000002004, "R6 overwrite");

    // R7: eight large fills after the flush wrap the pointer and replace the first
    for (int k = 0; k < 8; k++)
      do_fill(1'b0, 1'b1, 1'b0, 48'(k + 16) << 21, 40'(k + 1) << 21);
    do_look(1'b0, (48'd16 << 21) | 48'h55, 1'b0, 40'h0, "R7 evicted");
    do_look(1'b0, (48'd17 << 21) | 48'h55, 1'b1, (40'd2 << 21) | 40'h55, "R7 kept");
    do_look(1'b0, (48'd22 << 21) | 48'h55, 1'b1, (40'd7 << 21) | 40'h55, "R7 kept");
    do_look(1'b0, (48'd23 << 21) | 48'h55, 1'b1, (40'd8 << 21) | 40'h55, "R7 wrap");

    // R5: large entry wins over a small entry for the same address
    do_fill(1'b1, 1'b0, 1'b0, 48'h000000600000, 40'h0022222000);
    do_look(1'b1, 48'h000000600123, 1'b1, 40'h0022222123, "R5 small only");
    do_fill(1'b1, 1'b1, 1'b0, 48'h000000600000, 40'h000A000000);
    do_look(1'b1, 48'h000000600123, 1'b1, 40'h000A000123, "R5 priority");

    // R10: fill together with an invalidate is dropped
    @(negedge clk);
    inv_thread = 1'b1; inv_tid = 1'b0;
    fill_valid = 1'b1; fill_tid = 1'b0; fill_large = 1'b0; fill_va = 48'h00000000A000; fill_pa = 40'h0000777000;
    @(negedge clk);
    inv_thread = 1'b0; fill_valid = 1'b0;
    do_look(1'b0, 48'h00000000A000, 1'b0, 40'h0, "R10 fill dropped");

    // R10: a lookup in the invalidate cycle sees the old contents
    @(negedge clk);
    inv_all = 1'b1; req_valid = 1'b1; req_tid = 1'b1; req_va = 48'h000000600123;
    @(posedge clk);
    #1;
    check(rsp_valid && rsp_hit && rsp_pa == 40'h000A000123, "R10 old contents",
          {6'd0, rsp_valid, rsp_hit, rsp_pa}, {8'h03, 40'h000A000123});
    @(negedge clk);
    inv_all = 1'b0; req_valid = 1'b0;
    do_look(1'b1, 48'h000000600123, 1'b0, 40'h0, "R10 then cleared");

    // R11: back-pressure holds the result and blocks the next request
    do_fill(1'b0, 1'b0, 1'b0, 48'h000000111000, 40'h0000AAA000);
    do_fill(1'b0, 1'b0, 1'b0, 48'h000000222000, 40'h0000BBB000);
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_tid = 1'b0; req_va = 48'h000000111001;
    @(posedge clk);
    #1;
    check(rsp_valid && !req_ready, "R11 stall", {46'd0, rsp_valid, req_ready}, {46'd0, 2'b10});
    @(negedge clk);
    req_va = 48'h000000222002;
    repeat (2) @(posedge clk);
    #1;
    check(rsp_valid && rsp_hit && rsp_pa == 40'h0000AAA001, "R11 hold",
          {8'd0, rsp_pa}, {8'd0, 40'h0000AAA001});
    @(negedge clk);
    rsp_ready = 1'b1;
    @(posedge clk);
    #1;
    check(rsp_valid && rsp_hit && rsp_pa == 40'h0000BBB002, "R11 release",
          {8'd0, rsp_pa}, {8'd0, 40'h0000BBB002});
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    #1;
    check(!rsp_valid, "R11 drained", {47'd0, rsp_valid}, 48'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule